// File: doc/BRIEF.md
# Privilege-Aware Interrupt Arbiter

This block decides, once per cycle, whether the hart should take an interrupt now, which privilege level will handle it, and which cause code it carries. It looks at the current privilege level (machine, supervisor or user), the two global enable bits for machine and supervisor level, the per-cause pending and enable vectors, and the machine delegation mask. All inputs are captured in one register stage. The decision is combinational logic on those registered copies.

Six causes are implemented. Three are machine-named: software 3, timer 7 and external 11. Three are supervisor-named: software 1, timer 5 and external 9. A supervisor-named cause is routed to supervisor level when its delegation bit is set. Otherwise it is routed to machine level. Machine-named causes always go to machine level. Whether an interrupt is globally enabled is not decided by one enable bit. It depends on how its target level compares with the level the hart is running at.

Top module: `irq_priv_arbiter`

## Requirements
- R1: Every input is sampled on the rising clock edge, and the outputs show the decision for those samples until the next edge. While `rst_n` is low, the sampled state is cleared, so `take` is 0.
- R2: A cause can be taken only when its pending bit and its enable bit are both 1 and it is globally enabled for its target level.
- R3: When the target level equals the current level, the cause is globally enabled only if that level's enable bit is 1 (`mie` for machine, `sie` for supervisor).
- R4: A cause whose target level is below the current level is never taken, whatever `mie` and `sie` hold. In particular, a supervisor-target cause is never taken at machine level.
- R5: A cause whose target level is above the current level is always globally enabled, whatever that level's enable bit holds.
- R6: The supervisor timer (cause 5) targets supervisor level when `deleg[5]` is 1. When `deleg[5]` is 0 it targets machine level and can be taken from any level, reporting `tgt_mode` = 3.
- R7: Only causes 1, 5 and 9 follow their `deleg` bit. Causes 3, 7 and 11 always target machine level, and every other `deleg` bit has no effect.
- R8: If any eligible cause targets machine level, one of those is selected before any cause that targets supervisor level.
- R9: Within one target level, the order from highest to lowest priority is 11, 3, 7, 9, 1, 5.
- R10: Pending bits other than 1, 3, 5, 7, 9 and 11 never cause a take. The current-level code 2 is treated as user level.
- R11: Level codes are 0 for user, 1 for supervisor and 3 for machine. When `take` is 0, `tgt_mode` and `cause` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sample stage |
| cur_mode | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| mie | input | 1 | Machine global interrupt enable |
| sie | input | 1 | Supervisor global interrupt enable |
| pend | input | NCAUSE | Pending interrupt bits, indexed by cause |
| enab | input | NCAUSE | Per-cause interrupt enable bits |
| deleg | input | NCAUSE | Machine delegation mask |
| take | output | 1 | Take an interrupt this cycle |
| tgt_mode | output | 2 | Level that handles the selected cause |
| cause | output | CW | Cause code of the selected interrupt |

## Verification
The bench builds the block with its default 16-entry vectors and 4-bit cause field. With that width every implemented cause exists, and so do ten unimplemented bit positions, which the bench can drive to show they are masked. The bench sweeps all 24 combinations of current level, `mie`, `sie` and `deleg[5]` with only the supervisor timer pending, and compares each result against a truth table it computes itself. The remaining stimulus covers the priority order as the winning cause is removed one at a time, the rule that machine-target causes win, reserved level code 2, and random vectors.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  // number of ranked causes; rank NRANK means "not implemented"
  localparam int NRANK = 6;

  // priority rank of a cause code, 0 is highest
  function automatic int prio_rank(input int c);
    case (c)
      11:      return 0;
      3:       return 1;
      7:       return 2;
      9:       return 3;
      1:       return 4;
      5:       return 5;
      default: return NRANK;
    endcase
  endfunction

  function automatic bit is_impl(input int c);
    return prio_rank(c) < NRANK;
  endfunction

  // supervisor-named causes follow their delegation bit
  function automatic bit is_delegable(input int c);
    return (c == 1) || (c == 5) || (c == 9);
  endfunction

  // ordering of privilege levels; reserved code 2 ranks as user
  function automatic logic [1:0] lvl_rank(input logic [1:0] m);
    case (m)
      PRV_M:   return 2'd2;
      PRV_S:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // global enable: higher target always on, lower target always off,
  // equal target follows that level's own enable bit
  function automatic logic glob_enable(input logic [1:0] cur, input logic [1:0] tgt,
                                       input logic mie, input logic sie);
    logic [1:0] rc, rt;
    rc = lvl_rank(cur);
    rt = lvl_rank(tgt);
    if (rt > rc)      return 1'b1;
    else if (rt < rc) return 1'b0;
    else              return (tgt == PRV_M) ? mie : sie;
  endfunction

endpackage

// File: rtl/irq_src_route.sv
module irq_src_route
  import irq_arb_pkg::*;
#(
  parameter int NCAUSE = 16
) (
  input  logic [1:0]        cur_mode,
  input  logic              mie,
  input  logic              sie,
  input  logic [NCAUSE-1:0] pend,
  input  logic [NCAUSE-1:0] enab,
  input  logic [NCAUSE-1:0] deleg,
  output logic [NCAUSE-1:0] elig_m,
  output logic [NCAUSE-1:0] elig_s
);

  function automatic logic [NCAUSE-1:0] impl_mask();
    logic [NCAUSE-1:0] m;
    for (int c = 0; c < NCAUSE; c++) m[c] = is_impl(c);
    return m;
  endfunction

  function automatic logic [NCAUSE-1:0] dlg_mask();
    logic [NCAUSE-1:0] m;
    for (int c = 0; c < NCAUSE; c++) m[c] = is_delegable(c);
    return m;
  endfunction

  localparam logic [NCAUSE-1:0] IMPL_MASK = impl_mask();
  localparam logic [NCAUSE-1:0] DLG_MASK  = dlg_mask();

  // per-cause target level and eligibility
  logic [NCAUSE-1:0] to_super;
  logic [NCAUSE-1:0] live;

  for (genvar c = 0; c < NCAUSE; c++) begin : g_src
    logic [1:0] tgt;
    logic       gen;
    assign to_super[c] = DLG_MASK[c] & deleg[c];
    assign tgt         = to_super[c] ? PRV_S : PRV_M;
    assign gen         = glob_enable(cur_mode, tgt, mie, sie);
    assign live[c]     = IMPL_MASK[c] & pend[c] & enab[c] & gen;
    assign elig_m[c]   = live[c] & ~to_super[c];
    assign elig_s[c]   = live[c] &  to_super[c];
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NCAUSE = 16,
  parameter int CW     = 4
) (
  input  logic [NCAUSE-1:0] elig,
  output logic              hit,
  output logic [CW-1:0]     idx
);

  int best;

  always_comb begin
    best = NRANK;
    idx  = '0;
    for (int c = 0; c < NCAUSE; c++) begin
      if (elig[c] && (prio_rank(c) < best)) begin
        best = prio_rank(c);
        idx  = CW'(c);
      end
    end
    hit = (best < NRANK);
  end

endmodule

// File: rtl/irq_priv_arbiter.sv
module irq_priv_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NCAUSE = 16,
  parameter int CW     = $clog2(NCAUSE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cur_mode,
  input  logic              mie,
  input  logic              sie,
  input  logic [NCAUSE-1:0] pend,
  input  logic [NCAUSE-1:0] enab,
  input  logic [NCAUSE-1:0] deleg,
  output logic              take,
  output logic [1:0]        tgt_mode,
  output logic [CW-1:0]     cause
);

  // sample stage
  logic [1:0]        cur_q;
  logic              mie_q, sie_q;
  logic [NCAUSE-1:0] pend_q, enab_q, deleg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= PRV_U;
      mie_q   <= 1'b0;
      sie_q   <= 1'b0;
      pend_q  <= '0;
      enab_q  <= '0;
      deleg_q <= '0;
    end else begin
      cur_q   <= cur_mode;
      mie_q   <= mie;
      sie_q   <= sie;
      pend_q  <= pend;
      enab_q  <= enab;
      deleg_q <= deleg;
    end
  end

  // routing and eligibility
  logic [NCAUSE-1:0] elig_m, elig_s;

  irq_src_route #(.NCAUSE(NCAUSE)) u_route (
    .cur_mode (cur_q),
    .mie      (mie_q),
    .sie      (sie_q),
    .pend     (pend_q),
    .enab     (enab_q),
    .deleg    (deleg_q),
    .elig_m   (elig_m),
    .elig_s   (elig_s)
  );

  // one picker per target level
  logic [1:0]          hit_lvl;
  logic [1:0][CW-1:0]  idx_lvl;

  for (genvar l = 0; l < 2; l++) begin : g_pick
    irq_prio_pick #(.NCAUSE(NCAUSE), .CW(CW)) u_pick (
      .elig (l == 0 ? elig_m : elig_s),
      .hit  (hit_lvl[l]),
      .idx  (idx_lvl[l])
    );
  end

  // machine target wins over supervisor target
  always_comb begin
    take     = 1'b0;
    tgt_mode = PRV_U;
    cause    = '0;
    if (hit_lvl[0]) begin
      take     = 1'b1;
      tgt_mode = PRV_M;
      cause    = idx_lvl[0];
    end else if (hit_lvl[1]) begin
      take     = 1'b1;
      tgt_mode = PRV_S;
      cause    = idx_lvl[1];
    end
  end

  // named events for the checks
  logic took_s, took_m, same_lvl;
  assign took_s   = take && (tgt_mode == PRV_S);
  assign took_m   = take && (tgt_mode == PRV_M);
  assign same_lvl = take && (lvl_rank(tgt_mode) == lvl_rank(cur_q));

  AST_TAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend_q[cause] && enab_q[cause])); // R2
  AST_SAME_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    same_lvl |-> ((tgt_mode == PRV_M) ? mie_q : sie_q)); // R3
  AST_NO_S_AT_M: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == PRV_M) |-> !took_s); // R4
  AST_S_NEEDS_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
    took_s |-> deleg_q[cause]); // R7
  AST_M_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    took_s |-> (elig_m == '0)); // R8
  AST_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (prio_rank(int'(cause)) < NRANK)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (cause == '0 && tgt_mode == PRV_U)); // R11
  AST_M_TARGET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    took_m |-> !(deleg_q[cause] && is_delegable(int'(cause)))); // R6

endmodule

// File: tb/irq_priv_arbiter_tb_top.sv
module irq_priv_arbiter_tb_top;

  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cur_mode = 2'd0;
  logic          mie = 1'b0, sie = 1'b0;
  logic [NC-1:0] pend = '0, enab = '0, deleg = '0;
  logic          take;
  logic [1:0]    tgt_mode;
  logic [3:0]    cause;

  always #5 clk = ~clk;

  irq_priv_arbiter #(.NCAUSE(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .mie(mie), .sie(sie),
    .pend(pend), .enab(enab), .deleg(deleg),
    .take(take), .tgt_mode(tgt_mode), .cause(cause)
  );

  typedef struct {
    logic       tk;
    logic [1:0] tm;
    logic [3:0] cs;
    string      tag;
    int         stamp;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model written from the requirements
  function automatic int lvl(input logic [1:0] m);
    return (m == 2'd3) ? 2 : ((m == 2'd1) ? 1 : 0);
  endfunction

  function automatic exp_t model(input logic [1:0] md, input logic me, input logic se,
                                 input logic [NC-1:0] p, input logic [NC-1:0] e,
                                 input logic [NC-1:0] d);
    int   order[6] = '{11, 3, 7, 9, 1, 5};
    exp_t r;
    r.tk = 0; r.tm = 2'd0; r.cs = 4'd0; r.tag = ""; r.stamp = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 6; k++) begin
        int         c;
        logic [1:0] t;
        logic       ok;
        c = order[k];
        t = ((c == 1 || c == 5 || c == 9) && d[c]) ? 2'd1 : 2'd3;
        if ((pass == 0) != (t == 2'd3)) continue;
        if (lvl(t) > lvl(md))       ok = 1;
        else if (lvl(t) < lvl(md))  ok = 0;
        else                        ok = (t == 2'd3) ? me : se;
        if (!r.tk && p[c] && e[c] && ok) begin
          r.tk = 1; r.tm = t; r.cs = 4'(c);
        end
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [1:0] md, input logic me, input logic se,
                       input logic [NC-1:0] p, input logic [NC-1:0] e,
                       input logic [NC-1:0] d, input string tag);
    exp_t x;
    @(posedge clk);
    #2;
    cur_mode = md; mie = me; sie = se; pend = p; enab = e; deleg = d;
    x = model(md, me, se, p, e, d);
    x.tag = tag;
    x.stamp = cyc;
    q.push_back(x);
  endtask

  // monitor: compares one expected item per cycle once it is due
  always @(negedge clk) begin
    if (q.size() > 0 && cyc > q[0].stamp) begin
      exp_t x;
      x = q.pop_front();
      n_cmp++;
      if (take !== x.tk || tgt_mode !== x.tm || cause !== x.cs) begin
        n_bad++;
        $display("FAIL %s: got take=%0b tgt=%0d cause=%0d, want take=%0b tgt=%0d cause=%0d",
                 x.tag, take, tgt_mode, cause, x.tk, x.tm, x.cs);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got running, want finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NC-1:0] all6;
    all6 = 16'h0AAA;
    // R1: reset holds take low even with live inputs
    cur_mode = 2'd0; pend = all6; enab = all6; mie = 1; sie = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (take !== 1'b0 || cause !== 4'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got take=%0b cause=%0d, want take=0 cause=0", take, cause);
    end
    @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: one-cycle sampling of a single cause
    drive(2'd0, 0, 0, 16'h0800, 16'h0800, 16'h0, "R1");
    drive(2'd0, 0, 0, 16'h0000, 16'h0800, 16'h0, "R1");

    // R6 sweep of supervisor timer: level x mie x sie x deleg5; tag by relation
    for (int mi = 0; mi < 3; mi++) begin
      for (int b = 0; b < 8; b++) begin
        logic [1:0] md;
        logic       d5;
        int         tl;
        string      tg;
        md = (mi == 0) ? 2'd0 : ((mi == 1) ? 2'd1 : 2'd3);
        d5 = b[2];
        tl = d5 ? 1 : 2;
        if (tl == lvl(md))      tg = "R3/R6";
        else if (tl < lvl(md))  tg = "R4/R6";
        else                    tg = "R5/R6";
        drive(md, b[0], b[1], 16'h0020, 16'h0020, {10'b0, d5, 5'b0}, tg);
      end
    end

    // R8: machine-target beats supervisor-target regardless of rank
    drive(2'd0, 0, 0, 16'h0220, 16'h0220, 16'h0200, "R8");
    drive(2'd1, 0, 0, 16'h0A22, 16'h0A22, 16'h0A22, "R8");
    drive(2'd3, 1, 1, 16'h0002, 16'h0002, 16'h0000, "R8");

    // R9: strip the winner one by one, delegation off then on
    for (int dl = 0; dl < 2; dl++) begin
      logic [NC-1:0] p;
      p = all6;
      for (int k = 0; k < 7; k++) begin
        drive(2'd0, 1, 1, p, all6, dl ? 16'h0222 : 16'h0000, "R9");
        if      (p[11]) p[11] = 0;
        else if (p[3])  p[3]  = 0;
        else if (p[7])  p[7]  = 0;
        else if (p[9])  p[9]  = 0;
        else if (p[1])  p[1]  = 0;
        else            p[5]  = 0;
      end
    end

    // R7: machine-named causes ignore their deleg bits
    drive(2'd3, 1, 0, 16'h0888, 16'h0888, 16'hFFFF, "R7");
    drive(2'd3, 0, 1, 16'h0080, 16'h0080, 16'hFFFF, "R7");

    // R2: enable missing, pending missing
    drive(2'd0, 1, 1, all6, 16'h0000, 16'h0, "R2");
    drive(2'd0, 1, 1, 16'h0000, all6, 16'h0, "R2");

    // R10: unimplemented bits, reserved level code 2
    drive(2'd3, 1, 1, 16'hF555, 16'hFFFF, 16'hFFFF, "R10");
    drive(2'd2, 0, 0, 16'h0020, 16'h0020, 16'h0020, "R10");

    // R11: idle outputs
    drive(2'd3, 0, 0, all6, all6, 16'h0, "R11");

    // random vectors
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      drive(md, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), "R2");
    end

    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule